// File: doc/BRIEF.md
# Bus Initiator Address-Phase Sequencer

This block is the initiating side of a simple synchronous bus on which address and data share the same 32 wires. A local client hands over a request: a 64-bit address, a 4-bit command, 32-bit write data, active-low byte enables and a one-cycle start strobe. The block copies the request and then drives the address phase. That phase takes one cycle when the upper address half is zero. It takes two cycles when the upper half is nonzero: first the low half with a fixed extension code on the command lanes, then the high half with the real command.

After the last address cycle the block watches a single claim input for a bounded number of cycles. If a target claims in that window, the block runs exactly one data phase. On a write it drives the data. On a read it samples the data at the end of the data cycle. If no target claims in time, the block ends the transaction itself and flags an abort. An aborted read returns all ones. In both cases completion is a one-cycle done pulse.

Top module: `bus_init_seq`

## Requirements
- R1: After reset: busy, done and abort are 0, rdata is 0, the bus is released (bus_ad_oe 0, bus_ad_out 0, bus_active 0) and bus_cbe_n is 4'hF.
- R2: When req_addr[63:32] is zero, the address phase is one cycle, in the cycle after start. In it bus_ad_out carries req_addr[31:0], bus_cbe_n carries the command, and bus_ad_oe and bus_active are 1.
- R3: When req_addr[63:32] is nonzero, the address phase is two cycles. The first carries req_addr[31:0] with the extension code 4'b1101 on bus_cbe_n. The second carries req_addr[63:32] with the command.
- R4: Command bit 0 selects the direction: 1 is a write, 0 is a read. After the address phase bus_cbe_n carries req_be_n (active low, bit i for byte lane i) while bus_active is 1. On a write bus_ad_oe is 1 and bus_ad_out is the write data. On a read bus_ad_oe is 0.
- R5: If bus_claim is 1 in any of the first CLAIM_WAIT cycles after the last address cycle, the block runs exactly one data cycle after that cycle. Done follows in the next cycle with abort 0.
- R6: If bus_claim stays 0 for those CLAIM_WAIT cycles, done follows at once with abort 1 and no data cycle.
- R7: An aborted read reports rdata 32'hFFFFFFFF with done. A write reports rdata 0.
- R8: A claimed read reports with done the value of bus_ad_in sampled at the end of the data cycle.
- R9: busy is 1 from the cycle after start up to and including the done cycle. done is high for exactly one cycle.
- R10: A start while busy is 1 is ignored, and request inputs that change after start do not affect the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Start strobe for a new request |
| req_addr | input | 64 | Request address |
| req_cmd | input | 4 | Command code; bit 0 is 1 for a write |
| req_wdata | input | 32 | Write data |
| req_be_n | input | 4 | Active-low byte enables |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | With done: no target claimed |
| rdata | output | 32 | With done: read result |
| bus_ad_out | output | 32 | Shared address/data value driven |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_cbe_n | output | 4 | Command or byte-enable lanes |
| bus_active | output | 1 | Transaction framing, high from address to data phase |
| bus_claim | input | 1 | Target claim |
| bus_ad_in | input | 32 | Data returned by the target |

## Verification
The bench builds the block with a 64-bit address, 32-bit data and CLAIM_WAIT set to 4 instead of 5. The shorter window makes both edges of the window cheap to reach: a claim in the last allowed cycle still wins, and a silent target aborts after exactly four waiting cycles. The address value 64'h1_0000_0000 puts a single set bit in the upper half, so it drives the choice between one and two address cycles through its narrowest case. Stray starts are issued during the waiting cycles and in the done cycle, and the request inputs are scrambled after each start.

// File: rtl/bis_pkg.sv
package bis_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADR_EXT,
      ST_ADR,
      ST_WAIT,
      ST_DATA,
      ST_FIN
   } bis_state_e;

   localparam logic [3:0] EXT_CODE = 4'b1101;
endpackage

// File: rtl/bis_req_latch.sv
module bis_req_latch #(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 32,
   parameter int CMD_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic [CMD_W-1:0]    in_cmd,
   input  logic [DATA_W-1:0]   in_wdata,
   input  logic [DATA_W/8-1:0] in_be_n,
   output logic                need_ext_d,
   output logic                need_ext,
   output logic [DATA_W-1:0]   addr_lo,
   output logic [DATA_W-1:0]   addr_hi,
   output logic [CMD_W-1:0]    cmd,
   output logic [DATA_W-1:0]   wdata,
   output logic [DATA_W/8-1:0] be_n,
   output logic                is_write
);
   localparam int BE_W = DATA_W / 8;

   logic [ADDR_W-1:0] addr_q;
   logic              ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cmd     <= '0;
         wdata   <= '0;
         be_n    <= {BE_W{1'b1}};
         ext_q   <= 1'b0;
      end else if (load) begin
         addr_q  <= in_addr;
         cmd     <= in_cmd;
         wdata   <= in_wdata;
         be_n    <= in_be_n;
         ext_q   <= need_ext_d;
      end
   end

   assign is_write = cmd[0];
   assign need_ext = ext_q;
   assign addr_lo  = addr_q[DATA_W-1:0];

   generate
      if (ADDR_W > DATA_W) begin : g_wide
         assign need_ext_d = |in_addr[ADDR_W-1:DATA_W];
         assign addr_hi    = addr_q[ADDR_W-1:DATA_W];
      end else begin : g_narrow
         assign need_ext_d = 1'b0;
         assign addr_hi    = '0;
      end
   endgenerate
endmodule

// File: rtl/bis_claim_timer.sv
module bis_claim_timer #(
   parameter int WAIT = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = $clog2(WAIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (run && cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/bis_fsm.sv
module bis_fsm
   import bis_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       need_ext_d,
   input  logic       claim,
   input  logic       expired,
   output bis_state_e state,
   output logic       load,
   output logic       tmr_clear,
   output logic       tmr_run,
   output logic       capture,
   output logic       timeout
);
   bis_state_e nxt;

   always_comb begin
      nxt       = state;
      load      = 1'b0;
      capture   = 1'b0;
      timeout   = 1'b0;
      tmr_clear = (state == ST_ADR);
      tmr_run   = (state == ST_WAIT);
      unique case (state)
         ST_IDLE:
            if (start) begin
               load = 1'b1;
               nxt  = need_ext_d ? ST_ADR_EXT : ST_ADR;
            end
         ST_ADR_EXT: nxt = ST_ADR;
         ST_ADR:     nxt = ST_WAIT;
         ST_WAIT:
            if (claim)
               nxt = ST_DATA;
            else if (expired) begin
               timeout = 1'b1;
               nxt     = ST_FIN;
            end
         ST_DATA: begin
            capture = 1'b1;
            nxt     = ST_FIN;
         end
         ST_FIN:  nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   p_ext_then_adr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ADR_EXT |=> state == ST_ADR);
   p_data_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DATA |=> state == ST_FIN);
   p_fin_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FIN |=> state == ST_IDLE);
endmodule

// File: rtl/bis_result.sv
module bis_result #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              capture,
   input  logic              timeout,
   input  logic              is_write,
   input  logic [DATA_W-1:0] bus_data,
   output logic [DATA_W-1:0] rdata_q,
   output logic              abort_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         abort_q <= 1'b0;
      end else if (load) begin
         rdata_q <= '0;
         abort_q <= 1'b0;
      end else if (timeout) begin
         abort_q <= 1'b1;
         rdata_q <= is_write ? '0 : '1;
      end else if (capture && !is_write) begin
         rdata_q <= bus_data;
      end
   end
endmodule

// File: rtl/bus_init_seq.sv
module bus_init_seq
   import bis_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int DATA_W     = 32,
   parameter int CMD_W      = 4,
   parameter int CLAIM_WAIT = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_start,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [CMD_W-1:0]    req_cmd,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be_n,
   output logic                busy,
   output logic                done,
   output logic                abort,
   output logic [DATA_W-1:0]   rdata,
   output logic [DATA_W-1:0]   bus_ad_out,
   output logic                bus_ad_oe,
   output logic [CMD_W-1:0]    bus_cbe_n,
   output logic                bus_active,
   input  logic                bus_claim,
   input  logic [DATA_W-1:0]   bus_ad_in
);
   localparam int BE_W = DATA_W / 8;

   generate
      if (ADDR_W != DATA_W && ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("ADDR_W must equal DATA_W or twice DATA_W");
      end
      if (CLAIM_WAIT < 1) begin : g_bad_wait
         $error("CLAIM_WAIT must be at least 1");
      end
      if (CMD_W != BE_W || CMD_W != 4) begin : g_bad_cmd
         $error("CMD_W must be 4 and match the byte lane count");
      end
   endgenerate

   bis_state_e        state;
   logic              load, tmr_clear, tmr_run, capture, timeout, expired;
   logic              need_ext_d, need_ext, is_write, abort_q;
   logic [DATA_W-1:0] addr_lo, addr_hi, wdata, rdata_q;
   logic [CMD_W-1:0]  cmd;
   logic [BE_W-1:0]   be_n;

   bis_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_req (
      .clk(clk), .rst_n(rst_n), .load(load),
      .in_addr(req_addr), .in_cmd(req_cmd), .in_wdata(req_wdata), .in_be_n(req_be_n),
      .need_ext_d(need_ext_d), .need_ext(need_ext),
      .addr_lo(addr_lo), .addr_hi(addr_hi), .cmd(cmd),
      .wdata(wdata), .be_n(be_n), .is_write(is_write)
   );

   bis_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(req_start), .need_ext_d(need_ext_d),
      .claim(bus_claim), .expired(expired), .state(state), .load(load),
      .tmr_clear(tmr_clear), .tmr_run(tmr_run), .capture(capture), .timeout(timeout)
   );

   bis_claim_timer #(.WAIT(CLAIM_WAIT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run), .expired(expired)
   );

   bis_result #(.DATA_W(DATA_W)) u_res (
      .clk(clk), .rst_n(rst_n), .load(load), .capture(capture), .timeout(timeout),
      .is_write(is_write), .bus_data(bus_ad_in), .rdata_q(rdata_q), .abort_q(abort_q)
   );

   assign busy  = (state != ST_IDLE);
   assign done  = (state == ST_FIN);
   assign abort = done && abort_q;
   assign rdata = done ? rdata_q : '0;

   always_comb begin
      bus_ad_out = '0;
      bus_ad_oe  = 1'b0;
      bus_cbe_n  = '1;
      bus_active = 1'b0;
      unique case (state)
         ST_ADR_EXT: begin
            bus_ad_out = addr_lo;
            bus_ad_oe  = 1'b1;
            bus_cbe_n  = EXT_CODE;
            bus_active = 1'b1;
         end
         ST_ADR: begin
            bus_ad_out = need_ext ? addr_hi : addr_lo;
            bus_ad_oe  = 1'b1;
            bus_cbe_n  = cmd;
            bus_active = 1'b1;
         end
         ST_WAIT, ST_DATA: begin
            bus_ad_out = is_write ? wdata : '0;
            bus_ad_oe  = is_write;
            bus_cbe_n  = be_n;
            bus_active = 1'b1;
         end
         default: ;
      endcase
   end

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !busy) |=> busy);
   p_abort_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> done);
   p_abort_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !is_write) |-> rdata == '1);
   p_read_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !is_write) |-> !bus_ad_oe);
   p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

// File: tb/sim_bus_init_seq.sv
module sim_bus_init_seq;
   localparam int CW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic [63:0] req_addr = '0;
   logic [3:0]  req_cmd = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be_n = 4'hF;
   logic        busy, done, abort, bus_ad_oe, bus_active;
   logic [31:0] rdata, bus_ad_out;
   logic [3:0]  bus_cbe_n;
   logic        bus_claim = 1'b0;
   logic [31:0] bus_ad_in = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   bus_init_seq #(.ADDR_W(64), .DATA_W(32), .CMD_W(4), .CLAIM_WAIT(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
      .req_cmd(req_cmd), .req_wdata(req_wdata), .req_be_n(req_be_n),
      .busy(busy), .done(done), .abort(abort), .rdata(rdata),
      .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_cbe_n(bus_cbe_n),
      .bus_active(bus_active), .bus_claim(bus_claim), .bus_ad_in(bus_ad_in)
   );

   // packed view: oe, ad, cbe, active, busy, done, abort, rdata
   logic [72:0] exp_q[$];
   string       tag_q[$];

   function automatic logic [72:0] pk(logic oe, logic [31:0] ad, logic [3:0] cbe, logic act,
                                      logic bsy, logic dn, logic ab, logic [31:0] rd);
      return {oe, ad, cbe, act, bsy, dn, ab, rd};
   endfunction

   task automatic compare(logic [72:0] e, string tag);
      logic [72:0] got;
      got = {bus_ad_oe, bus_ad_out, bus_cbe_n, bus_active, busy, done, abort, rdata};
      n_cmp++;
      if (got !== e) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, e);
      end
   endtask

   // k: claim in waiting cycle k (0-based); k >= CW means no claim
   task automatic run_txn(logic [63:0] a, logic [3:0] c, logic [31:0] wd, logic [3:0] be,
                          int k, logic [31:0] rv, int stray, string tag);
      bit ext = (a[63:32] != 0);
      bit wr  = c[0];
      bit claimed = (k < CW);
      int nadr = ext ? 2 : 1;
      int cidx = nadr + k + 1;
      int didx = nadr + k + 2;
      int nw = claimed ? k + 1 : CW;
      logic [31:0] res;
      exp_q.delete(); tag_q.delete();
      if (ext) begin
         exp_q.push_back(pk(1, a[31:0], 4'b1101, 1, 1, 0, 0, 0)); tag_q.push_back({tag, " R3 ext cycle"});
         exp_q.push_back(pk(1, a[63:32], c, 1, 1, 0, 0, 0)); tag_q.push_back({tag, " R3 high cycle"});
      end else begin
         exp_q.push_back(pk(1, a[31:0], c, 1, 1, 0, 0, 0)); tag_q.push_back({tag, " R2 single addr"});
      end
      for (int i = 0; i < nw; i++) begin
         exp_q.push_back(pk(wr, wr ? wd : 32'h0, be, 1, 1, 0, 0, 0)); tag_q.push_back({tag, " R4 wait R10"});
      end
      if (claimed) begin
         exp_q.push_back(pk(wr, wr ? wd : 32'h0, be, 1, 1, 0, 0, 0)); tag_q.push_back({tag, " R5 data"});
      end
      if (wr) res = 32'h0;
      else    res = claimed ? rv : 32'hFFFF_FFFF;
      exp_q.push_back(pk(0, 0, 4'hF, 0, 1, 1, !claimed, res));
      tag_q.push_back(claimed ? {tag, " R5 R8 done"} : {tag, " R6 R7 done"});
      exp_q.push_back(pk(0, 0, 4'hF, 0, 0, 0, 0, 0)); tag_q.push_back({tag, " R9 idle after"});

      @(negedge clk);
      req_addr = a; req_cmd = c; req_wdata = wd; req_be_n = be; req_start = 1'b1;
      for (int i = 1; i <= exp_q.size(); i++) begin
         @(negedge clk);
         compare(exp_q[i-1], tag_q[i-1]);
         req_start = (i == stray);
         if (i == 1) begin
            req_addr = ~a; req_cmd = ~c; req_wdata = ~wd; req_be_n = ~be;
         end
         bus_claim = claimed && (i == cidx);
         bus_ad_in = (i == didx) ? rv : 32'hDEAD_0000 + i;
      end
      req_start = 1'b0;
      bus_claim = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare(pk(0, 0, 4'hF, 0, 0, 0, 0, 0), "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      compare(pk(0, 0, 4'hF, 0, 0, 0, 0, 0), "R1 after reset");
      run_txn(64'h0000_0000_1234_5678, 4'b0111, 32'hCAFE_F00D, 4'b0010, 0, 0, 2, "t1 wr single");
      run_txn(64'h89AB_CDEF_0000_1000, 4'b0110, 32'h0, 4'b0000, 2, 32'hA5A5_0F0F, 0, "t2 rd dual");
      run_txn(64'h0000_0000_0000_0040, 4'b0010, 32'h0, 4'b1100, CW, 0, 3, "t3 rd abort");
      run_txn(64'h0000_0001_0000_0000, 4'b0011, 32'h1111_2222, 4'b0101, CW, 0, 0, "t4 wr dual abort");
      run_txn(64'h0000_0000_FFFF_FFFC, 4'b1100, 32'h0, 4'b0000, CW - 1, 32'h0BAD_BEEF, 0, "t5 rd last claim");
      run_txn(64'h0000_0000_0000_0800, 4'b0111, 32'h7777_8888, 4'b1110, 1, 0, 5, "t6 wr stray in done");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired got=hung exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule